// File: doc/BRIEF.md
# Iteration-Count Read-Precision Controller

This controller sits beside a soft-decision page decoder and picks how many bits of read precision the flash sensing path should use for the pages that follow. It watches one report for each finished decode: how many iterations the decoder needed, whether the decode failed, and how many bits were corrected in each direction (a stored 1 read as 0, and a stored 0 read as 1). From these reports it keeps one of three precision levels: 1.0, 1.4 or 2.0 bits for each data bit.

The level goes up before a decode fails, once the iteration count shows that the decoder is working harder. It comes down again when decodes stay easy. Each move needs an unbroken run of qualifying reports, so the level does not flip back and forth on one noisy page. A failed decode moves the level up at once. At the top level, lasting heavy effort or a failure raises a one-cycle request for a full channel re-estimation. A separate comparator flags a clear imbalance between the two error directions and gives the direction in which the sensing reference voltages should move.

All outputs are registered. They change only in the cycle after a report strobe. The repeat length, the iteration thresholds and the imbalance rule are parameters.

Top module: `prec_adapt_ctrl`

## Requirements
- R1: After reset, `prec_o` reads 0 (1.0-bit) and `chan_est_req_o`, `vref_adj_o` and `vref_dir_o` all read 0.
- R2: `prec_o` encodes the level as 0 = 1.0-bit, 1 = 1.4-bit and 2 = 2.0-bit. The value 3 never appears. A single report changes the level by at most one step.
- R3: At level 0, REPEAT_N (default 4) consecutive non-failing reports with an iteration count of 2 or more move the level to 1. Any report that does not qualify restarts the run.
- R4: At level 1, REPEAT_N consecutive non-failing reports with an iteration count of exactly 1 move the level to 0.
- R5: At level 1, REPEAT_N consecutive non-failing reports with an iteration count of 3 or more move the level to 2.
- R6: At level 2, REPEAT_N consecutive non-failing reports with an iteration count of 2 or less move the level to 1.
- R7: At level 2, REPEAT_N consecutive non-failing reports with an iteration count of 4 or more pulse `chan_est_req_o` high for one cycle. A new run of REPEAT_N is then needed for the next pulse. `chan_est_req_o` is never high while `prec_o` is not 2.
- R8: A report with the fail flag set moves the level up one step at once from level 0 or 1. At level 2 it pulses `chan_est_req_o` instead. In every case it restarts all runs.
- R9: Every change of level restarts all runs. A run therefore counts only reports made at the new level.
- R10: When the sum of the two error counts is at least 8 and one count is more than twice the other, `vref_adj_o` pulses for one cycle. `vref_dir_o` is then set to 1 if the 1-to-0 count is the larger one and to 0 otherwise. `vref_dir_o` keeps its value until the next imbalanced report.
- R11: While `dec_done_i` is low, every other input is ignored. `prec_o` and `vref_dir_o` hold their values, and both pulse outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_done_i | input | 1 | One-cycle strobe: a decode report is valid |
| dec_iter_i | input | ITER_W | Iterations used by the reported decode |
| dec_fail_i | input | 1 | The reported decode did not converge |
| flip10_i | input | ERR_W | Corrected bits that were stored as 1 and read as 0 |
| flip01_i | input | ERR_W | Corrected bits that were stored as 0 and read as 1 |
| prec_o | output | 2 | Current precision level (encoding in R2) |
| chan_est_req_o | output | 1 | One-cycle request for channel re-estimation |
| vref_adj_o | output | 1 | One-cycle pulse: the error directions are imbalanced |
| vref_dir_o | output | 1 | Direction of the last imbalance: 1 means 1-to-0 errors dominated |

## Verification
The hardest state to reach is the stress request at the top level. The bench first needs unbroken runs that climb through level 1, and then it needs REPEAT_N heavy reports in a row that neither fail nor fall into the step-down band. A single stray report anywhere in that chain restarts it. Directed sequences walk the level up and down with runs broken one report short. A long pseudo-random report stream then draws iteration counts from a narrow range around the thresholds, so that long qualifying runs at every level happen often. A bench model, written from the rules, follows the stream report by report.

// File: rtl/prec_adapt_pkg.sv
package prec_adapt_pkg;

   typedef enum logic [1:0] {
      PREC_1P0 = 2'd0,
      PREC_1P4 = 2'd1,
      PREC_2P0 = 2'd2
   } prec_e;

   // Indices of the three run counters
   localparam int RUN_UP   = 0;
   localparam int RUN_DN   = 1;
   localparam int RUN_HOT  = 2;
   localparam int NUM_RUNS = 3;

   function automatic prec_e prec_step_up(input prec_e p);
      case (p)
         PREC_1P0: return PREC_1P4;
         default:  return PREC_2P0;
      endcase
   endfunction

   function automatic prec_e prec_step_dn(input prec_e p);
      case (p)
         PREC_2P0: return PREC_1P4;
         default:  return PREC_1P0;
      endcase
   endfunction

endpackage

// File: rtl/prec_qualify.sv
module prec_qualify
   import prec_adapt_pkg::*;
#(
   parameter int ITER_W      = 6,
   parameter int UP_LO_ITER  = 2,
   parameter int DN_MID_ITER = 1,
   parameter int UP_MID_ITER = 3,
   parameter int DN_HI_ITER  = 2,
   parameter int HOT_ITER    = 4
) (
   input  prec_e               level_i,
   input  logic [ITER_W-1:0]   iter_i,
   output logic [NUM_RUNS-1:0] hit_o
);
   localparam logic [ITER_W-1:0] UP_LO_T  = ITER_W'(UP_LO_ITER);
   localparam logic [ITER_W-1:0] DN_MID_T = ITER_W'(DN_MID_ITER);
   localparam logic [ITER_W-1:0] UP_MID_T = ITER_W'(UP_MID_ITER);
   localparam logic [ITER_W-1:0] DN_HI_T  = ITER_W'(DN_HI_ITER);
   localparam logic [ITER_W-1:0] HOT_T    = ITER_W'(HOT_ITER);

   always_comb begin
      hit_o = '0;
      case (level_i)
         PREC_1P0: begin
            hit_o[RUN_UP] = (iter_i >= UP_LO_T);
         end
         PREC_1P4: begin
            hit_o[RUN_UP] = (iter_i >= UP_MID_T);
            hit_o[RUN_DN] = (iter_i == DN_MID_T);
         end
         PREC_2P0: begin
            hit_o[RUN_DN]  = (iter_i <= DN_HI_T);
            hit_o[RUN_HOT] = (iter_i >= HOT_T);
         end
         default: hit_o = '0;
      endcase
   end
endmodule

// File: rtl/prec_run_cnt.sv
module prec_run_cnt #(
   parameter int REPEAT_N = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic step_i,
   input  logic hit_i,
   output logic full_o
);
   localparam int CW = (REPEAT_N < 2) ? 1 : $clog2(REPEAT_N);
   localparam logic [CW-1:0] LAST = CW'(REPEAT_N - 1);

   logic [CW-1:0] run_q;

   assign full_o = step_i & hit_i & (run_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (clear_i) begin
         run_q <= '0;
      end else if (step_i) begin
         if (hit_i && !full_o) run_q <= run_q + 1'b1;
         else                  run_q <= '0;
      end
   end
endmodule

// File: rtl/prec_skew.sv
module prec_skew #(
   parameter int ERR_W     = 10,
   parameter int RATIO     = 2,
   parameter int MIN_TOTAL = 8
) (
   input  logic [ERR_W-1:0] a_i,
   input  logic [ERR_W-1:0] b_i,
   output logic             skew_o,
   output logic             a_big_o
);
   localparam int RW = $clog2(RATIO + 1);
   localparam int SW = ERR_W + RW;
   localparam bit RATIO_POW2 = (RATIO > 0) && ((RATIO & (RATIO - 1)) == 0);
   localparam int RSH = $clog2(RATIO);

   logic [SW-1:0]    a_scaled, b_scaled;
   logic [ERR_W:0]   total;
   logic             a_dom, b_dom, enough;

   generate
      if (RATIO_POW2) begin : g_shift
         assign a_scaled = SW'(a_i) << RSH;
         assign b_scaled = SW'(b_i) << RSH;
      end else begin : g_mult
         assign a_scaled = SW'(a_i) * SW'(RATIO);
         assign b_scaled = SW'(b_i) * SW'(RATIO);
      end
   endgenerate

   assign total   = {1'b0, a_i} + {1'b0, b_i};
   assign enough  = (total >= (ERR_W+1)'(MIN_TOTAL));
   assign a_dom   = (SW'(a_i) > b_scaled);
   assign b_dom   = (SW'(b_i) > a_scaled);
   assign skew_o  = enough & (a_dom | b_dom);
   assign a_big_o = a_dom;
endmodule

// File: rtl/prec_adapt_ctrl.sv
module prec_adapt_ctrl
   import prec_adapt_pkg::*;
#(
   parameter int ITER_W      = 6,
   parameter int ERR_W       = 10,
   parameter int REPEAT_N    = 4,
   parameter int UP_LO_ITER  = 2,
   parameter int DN_MID_ITER = 1,
   parameter int UP_MID_ITER = 3,
   parameter int DN_HI_ITER  = 2,
   parameter int HOT_ITER    = 4,
   parameter int SKEW_RATIO  = 2,
   parameter int SKEW_MIN    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec_done_i,
   input  logic [ITER_W-1:0] dec_iter_i,
   input  logic              dec_fail_i,
   input  logic [ERR_W-1:0]  flip10_i,
   input  logic [ERR_W-1:0]  flip01_i,
   output logic [1:0]        prec_o,
   output logic              chan_est_req_o,
   output logic              vref_adj_o,
   output logic              vref_dir_o
);
   localparam int ITER_MAX = (1 << ITER_W) - 1;

   // elaboration-time parameter checks
   if (REPEAT_N < 1) begin : g_bad_repeat
      $error("REPEAT_N must be at least 1");
   end
   if (ITER_W < 2 || ITER_W > 16) begin : g_bad_iter_w
      $error("ITER_W out of range");
   end
   if (HOT_ITER > ITER_MAX || UP_MID_ITER > ITER_MAX || UP_LO_ITER > ITER_MAX) begin : g_bad_thr
      $error("iteration threshold does not fit ITER_W");
   end
   if (DN_HI_ITER >= HOT_ITER || DN_MID_ITER >= UP_MID_ITER) begin : g_bad_band
      $error("step-down band overlaps step-up band");
   end
   if (SKEW_RATIO < 1 || ERR_W < 2) begin : g_bad_skew
      $error("bad imbalance configuration");
   end

   prec_e               level_q, level_nxt;
   logic [NUM_RUNS-1:0] hit, full;
   logic                step, clear, req_nxt;
   logic                skew, a_big;

   prec_qualify #(
      .ITER_W      (ITER_W),
      .UP_LO_ITER  (UP_LO_ITER),
      .DN_MID_ITER (DN_MID_ITER),
      .UP_MID_ITER (UP_MID_ITER),
      .DN_HI_ITER  (DN_HI_ITER),
      .HOT_ITER    (HOT_ITER)
   ) u_qual (
      .level_i (level_q),
      .iter_i  (dec_iter_i),
      .hit_o   (hit)
   );

   assign step  = dec_done_i & ~dec_fail_i;
   assign clear = dec_done_i & (dec_fail_i | (level_nxt != level_q));

   for (genvar g = 0; g < NUM_RUNS; g++) begin : g_run
      prec_run_cnt #(.REPEAT_N(REPEAT_N)) u_run (
         .clk     (clk),
         .rst_n   (rst_n),
         .clear_i (clear),
         .step_i  (step),
         .hit_i   (hit[g]),
         .full_o  (full[g])
      );
   end

   always_comb begin
      level_nxt = level_q;
      req_nxt   = 1'b0;
      if (dec_done_i) begin
         if (dec_fail_i) begin
            if (level_q == PREC_2P0) req_nxt   = 1'b1;
            else                     level_nxt = prec_step_up(level_q);
         end else begin
            if (full[RUN_UP])      level_nxt = prec_step_up(level_q);
            else if (full[RUN_DN]) level_nxt = prec_step_dn(level_q);
            if (full[RUN_HOT])     req_nxt   = 1'b1;
         end
      end
   end

   prec_skew #(
      .ERR_W     (ERR_W),
      .RATIO     (SKEW_RATIO),
      .MIN_TOTAL (SKEW_MIN)
   ) u_skew (
      .a_i     (flip10_i),
      .b_i     (flip01_i),
      .skew_o  (skew),
      .a_big_o (a_big)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q        <= PREC_1P0;
         chan_est_req_o <= 1'b0;
         vref_adj_o     <= 1'b0;
         vref_dir_o     <= 1'b0;
      end else begin
         level_q        <= level_nxt;
         chan_est_req_o <= req_nxt;
         vref_adj_o     <= dec_done_i & skew;
         if (dec_done_i && skew) vref_dir_o <= a_big;
      end
   end

   assign prec_o = level_q;
endmodule

// File: rtl/prec_adapt_chk.sv
module prec_adapt_chk #(
   parameter int ITER_W = 6,
   parameter int ERR_W  = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dec_done_i,
   input logic [ITER_W-1:0] dec_iter_i,
   input logic              dec_fail_i,
   input logic [ERR_W-1:0]  flip10_i,
   input logic [ERR_W-1:0]  flip01_i,
   input logic [1:0]        prec_o,
   input logic              chan_est_req_o,
   input logic              vref_adj_o,
   input logic              vref_dir_o
);
   logic [ERR_W+1:0] tot;
   logic             ten_heavy;
   assign tot       = (ERR_W+2)'(flip10_i) + (ERR_W+2)'(flip01_i);
   assign ten_heavy = ((ERR_W+2)'(flip10_i) > ((ERR_W+2)'(flip01_i) << 1)) && (tot >= 8);

   // R2
   prec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prec_o != 2'd3);

   // R2
   prec_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (prec_o == $past(prec_o)) || (prec_o == 2'($past(prec_o) + 2'd1))
               || (2'(prec_o + 2'd1) == $past(prec_o)));

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_done_i |=> $stable(prec_o) && $stable(vref_dir_o) && !chan_est_req_o && !vref_adj_o);

   // R8
   fail_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_done_i && dec_fail_i && prec_o != 2'd2 |=> prec_o == 2'($past(prec_o) + 2'd1));

   // R8
   fail_est_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_done_i && dec_fail_i && prec_o == 2'd2 |=> chan_est_req_o && prec_o == 2'd2);

   // R7
   est_top_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_est_req_o |-> prec_o == 2'd2);

   // R10
   skew_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_done_i && ten_heavy |=> vref_adj_o && vref_dir_o);
endmodule

bind prec_adapt_ctrl prec_adapt_chk #(.ITER_W(ITER_W), .ERR_W(ERR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .dec_done_i     (dec_done_i),
   .dec_iter_i     (dec_iter_i),
   .dec_fail_i     (dec_fail_i),
   .flip10_i       (flip10_i),
   .flip01_i       (flip01_i),
   .prec_o         (prec_o),
   .chan_est_req_o (chan_est_req_o),
   .vref_adj_o     (vref_adj_o),
   .vref_dir_o     (vref_dir_o)
);

// File: tb/prec_adapt_ctrl_tb.sv
module prec_adapt_ctrl_tb;
   localparam int ITER_W = 6;
   localparam int ERR_W  = 10;
   localparam int N      = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              done = 1'b0;
   logic [ITER_W-1:0] iter = '0;
   logic              fail = 1'b0;
   logic [ERR_W-1:0]  e10 = '0;
   logic [ERR_W-1:0]  e01 = '0;
   logic [1:0]        prec;
   logic              est, adj, dir;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // bench model state
   int m_lvl = 0, m_up = 0, m_dn = 0, m_hot = 0;
   bit m_dir = 0, m_est = 0, m_adj = 0;

   always #5 clk = ~clk;

   prec_adapt_ctrl #(.ITER_W(ITER_W), .ERR_W(ERR_W), .REPEAT_N(N)) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .dec_done_i     (done),
      .dec_iter_i     (iter),
      .dec_fail_i     (fail),
      .flip10_i       (e10),
      .flip01_i       (e01),
      .prec_o         (prec),
      .chan_est_req_o (est),
      .vref_adj_o     (adj),
      .vref_dir_o     (dir)
   );

   task automatic check(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model(input int it, input bit fl, input int a, input int b);
      int nl;
      m_est = 0;
      m_adj = 0;
      if (a + b >= 8 && a > 2 * b) begin m_adj = 1; m_dir = 1; end
      else if (a + b >= 8 && b > 2 * a) begin m_adj = 1; m_dir = 0; end
      if (fl) begin
         if (m_lvl < 2) m_lvl++;
         else m_est = 1;
         m_up = 0; m_dn = 0; m_hot = 0;
      end else begin
         m_up  = ((m_lvl == 0 && it >= 2) || (m_lvl == 1 && it >= 3)) ? m_up + 1 : 0;
         m_dn  = ((m_lvl == 1 && it == 1) || (m_lvl == 2 && it <= 2)) ? m_dn + 1 : 0;
         m_hot = (m_lvl == 2 && it >= 4) ? m_hot + 1 : 0;
         nl = m_lvl;
         if (m_up == N) nl = m_lvl + 1;
         else if (m_dn == N) nl = m_lvl - 1;
         if (m_hot == N) begin m_est = 1; m_hot = 0; end
         if (nl != m_lvl) begin
            m_lvl = nl; m_up = 0; m_dn = 0; m_hot = 0;
         end
      end
   endtask

   // called at a falling edge; leaves the bench at a falling edge
   task automatic decode(input int it, input bit fl, input int a, input int b, input string tag);
      done = 1'b1;
      iter = ITER_W'(it);
      fail = fl;
      e10  = ERR_W'(a);
      e01  = ERR_W'(b);
      model(it, fl, a, b);
      @(posedge clk);
      @(negedge clk);
      done = 1'b0;
      check(int'(prec), m_lvl, {tag, " level"});
      check(int'(est), int'(m_est), {tag, " estimate request"});
      check(int'(adj), int'(m_adj), {tag, " R10 shift pulse"});
      check(int'(dir), int'(m_dir), {tag, " R10 direction"});
   endtask

   task automatic repeat_decode(input int cnt, input int it, input string tag);
      for (int k = 0; k < cnt; k++) decode(it, 1'b0, 0, 0, tag);
   endtask

   initial begin : watchdog
      #(200000 * 10);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] lfsr;
      logic [1:0]  p0;
      logic        d0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(int'(prec), 0, "R1 level");
      check(int'(est), 0, "R1 request");
      check(int'(adj), 0, "R1 shift");
      check(int'(dir), 0, "R1 direction");

      // R3: broken run, then full run
      repeat_decode(N - 1, 2, "R3 short run");
      decode(1, 1'b0, 0, 0, "R3 breaker");
      repeat_decode(N - 1, 5, "R3 rebuild");
      check(int'(prec), 0, "R3 still low before last");
      decode(2, 1'b0, 0, 0, "R3 completing");
      check(int'(prec), 1, "R3 raised");

      // R9: a run does not carry across levels; R4 step down
      repeat_decode(N - 1, 1, "R4 short run");
      decode(3, 1'b0, 0, 0, "R4 breaker");
      repeat_decode(N, 1, "R4 full run");
      check(int'(prec), 0, "R4 lowered");

      // R8 failures climb straight up, then request at top
      decode(0, 1'b1, 0, 0, "R8 fail at 1.0");
      check(int'(prec), 1, "R8 level 1");
      decode(0, 1'b1, 0, 0, "R8 fail at 1.4");
      check(int'(prec), 2, "R8 level 2");
      decode(9, 1'b1, 0, 0, "R8 fail at 2.0");
      check(int'(est), 1, "R8 request");

      // R7 stress run, R9 after failure runs restart
      repeat_decode(N - 1, 7, "R7 partial");
      decode(7, 1'b1, 0, 0, "R8 R9 fail clears");
      repeat_decode(N - 1, 7, "R7 rebuild");
      check(int'(est), 0, "R7 no early request");
      decode(4, 1'b0, 0, 0, "R7 completing");
      check(int'(est), 1, "R7 request");
      repeat_decode(N - 1, 6, "R7 restart");
      check(int'(est), 0, "R7 needs fresh run");

      // R6 step down from top, R5 climb again
      repeat_decode(N, 2, "R6 down run");
      check(int'(prec), 1, "R6 lowered");
      repeat_decode(N, 3, "R5 up run");
      check(int'(prec), 2, "R5 raised");

      // R10 imbalance corners
      decode(2, 1'b0, 5, 2, "R10 total 7 ignored");
      decode(2, 1'b0, 6, 3, "R10 exactly twice ignored");
      decode(2, 1'b0, 7, 3, "R10 10-heavy");
      decode(2, 1'b0, 3, 7, "R10 01-heavy");
      decode(2, 1'b0, 8, 0, "R10 one sided");
      decode(2, 1'b0, 4, 4, "R10 balanced keeps dir");

      // R11 inputs ignored without strobe
      p0 = prec;
      d0 = dir;
      iter = 6'd9; fail = 1'b1; e10 = 10'd50; e01 = 10'd0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         check(int'(prec), int'(p0), "R11 level held");
         check(int'(dir), int'(d0), "R11 direction held");
         check(int'(est) + int'(adj), 0, "R11 no pulses");
      end

      // R2 R3 R4 R5 R6 R7 R8 R10 pseudo-random sweep
      lfsr = 32'hACE1_2468;
      for (int k = 0; k < 4000; k++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         decode(int'(lfsr[2:0]) % 7, (lfsr[12:8] == 5'd3), int'(lfsr[17:13]),
                int'(lfsr[22:18]), "R2 R3 R4 R5 R6 R7 R8 sweep");
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule